// File: doc/BRIEF.md
# Command-Queue I2C Transaction Sequencer

This block sits between a command producer and a byte-level I2C bus engine. Software-side logic pushes packed 32-bit command words into one of two queues. A start vector then tells the sequencer to run a queue. The sequencer fetches the words in order and decodes them. It turns each command into a series of byte-level bus operations: an address phase, data bytes, and a stop. It also unpacks the data bytes of write commands, which are stored little-endian.

Bytes returned by read commands are packed into 32-bit words and held in a read buffer. The buffer's level can be observed, and the buffer is drained one word per pop. Completion reports, finished reads, NACKs and malformed commands are signalled as single-cycle event pulses for an interrupt block.

Each run is bounded by a word limit that is captured together with the start bit. If the bus engine answers with a NACK, the transaction is closed and the rest of that queue is discarded.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A word offered on the load port joins the selected queue (queue 0 holds up to 64 words, queue 1 up to 16). Its word count rises by one on the following cycle. While a queue is full, a further load is dropped and the count stays the same.
- R2: Start bit `MASTER_ID*2+q` of `start_vec` marks queue q for execution, and `run_words` is captured with it as the word limit. Bits that belong to other master indices have no effect.
- R3: The opcode is the low nibble of a command word. Opcode 1 loads the 7-bit slave address from bits [10:4]. Every address phase sends the byte {address, rw}, with rw = 0 for a write and rw = 1 for a read.
- R4: Opcode 9 is a write, with its byte count in bits [7:4]. The command byte and its data bytes are packed little-endian across successive words, and the command sits in byte 0. The bus sequence is: one address op (kind 0), then each data byte in order as a write op (kind 1), then a stop op (kind 3). Request, kind and byte stay steady until `bus_ack`.
- R5: Opcode 10 is a read of n bytes, with n in bits [7:4]. The bus sequence is: an address op, then n read ops (kind 2) with `bus_last` raised on the final one, then a stop op. The read buffer receives n/4+1 words: byte 0 of the first word holds the address byte {address, 1}, and the received bytes follow in little-endian order with zero padding. `ev_rd_done` pulses once, in the same cycle that `rd_level` shows the final count.
- R6: Opcode 8 is a report. If bit 8 is set, `ev_report[q]` pulses once. If bit 8 is clear, no event is raised.
- R7: A run stops once it has consumed the captured number of words, or earlier if the queue empties. Words beyond the limit stay in the queue for a later run.
- R8: A NACK on an address or write-data op is followed by a stop op. The queue is then emptied, `ev_nack[q]` pulses, and no later command of that queue executes.
- R9: An unknown opcode, or a write whose data words lie beyond the limit or the queue contents, pulses `ev_err[q]` and empties the queue. A write that is cut short this way still closes the bus with a stop op.
- R10: `rd_level` counts the buffered read words, `rd_word` shows the oldest one, and each `rd_pop` of a non-empty buffer lowers the level by one.
- R11: When both queues are pending, queue 0 runs first. A start that arrives during a run is held until the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Push `ld_word` into the selected queue |
| ld_sel | input | 1 | Target queue of the load |
| ld_word | input | 32 | Command or data word |
| start_vec | input | 2*NUM_MASTERS | Start bits, two per master index |
| run_words | input | CNTW | Word limit captured with a start bit |
| q0_words | output | CNTW | Words held in queue 0 |
| q1_words | output | CNTW | Words held in queue 1 |
| bus_req | output | 1 | Byte-level operation request |
| bus_kind | output | 2 | 0 address, 1 write byte, 2 read byte, 3 stop |
| bus_wdata | output | 8 | Byte sent for address or write ops |
| bus_last | output | 1 | Marks the final read byte |
| bus_ack | input | 1 | Operation finished |
| bus_nack | input | 1 | Slave refused the byte (valid with ack) |
| bus_rdata | input | 8 | Received byte (valid with ack) |
| rd_pop | input | 1 | Remove the oldest read-buffer word |
| rd_word | output | 32 | Oldest read-buffer word |
| rd_level | output | RBW | Read-buffer words pending |
| ev_report | output | 2 | Report reached, per queue |
| ev_rd_done | output | 1 | Read command finished |
| ev_nack | output | 2 | Queue aborted on NACK |
| ev_err | output | 2 | Queue aborted on malformed command |
| busy | output | 1 | A run is pending or active |

## Verification
Queue counts and the read level follow a load or pop by exactly one cycle. Event pulses appear in the cycle after the handshake that completes them, and the read level reaches its final value in the same cycle as the read-done pulse. The bench never predicts the sequencer's internal timing. It applies stimulus on falling edges, acknowledges every bus request on the falling edge after the request shows, waits until `busy` drops, and waits one more cycle before comparing counts, logged bus bytes and buffer words with values computed from the command fields.

// File: rtl/i2c_cmdseq_pkg.sv
package i2c_cmdseq_pkg;

    localparam int NQ = 2;

    localparam logic [3:0] OP_SETP   = 4'd1;
    localparam logic [3:0] OP_REPORT = 4'd8;
    localparam logic [3:0] OP_WRITE  = 4'd9;
    localparam logic [3:0] OP_READ   = 4'd10;

    typedef enum logic [1:0] {
        BK_ADDR  = 2'd0,
        BK_WRITE = 2'd1,
        BK_READ  = 2'd2,
        BK_STOP  = 2'd3
    } bus_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_EXEC,
        S_ADDR,
        S_WNEXT,
        S_WDATA,
        S_RDATA,
        S_STOP,
        S_ABORT
    } seq_state_e;

    function automatic logic [3:0] op_of(input logic [31:0] w);
        return w[3:0];
    endfunction

    function automatic logic [6:0] addr_of(input logic [31:0] w);
        return w[10:4];
    endfunction

    function automatic logic [3:0] len_of(input logic [31:0] w);
        return w[7:4];
    endfunction

    function automatic logic irq_of(input logic [31:0] w);
        return w[8];
    endfunction

endpackage

// File: rtl/cmdseq_word_fifo.sv
module cmdseq_word_fifo #(
    parameter int DEPTH = 16,
    parameter int CNTW  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [31:0]     din,
    input  logic            pop,
    input  logic            flush,
    output logic [31:0]     head,
    output logic [CNTW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [31:0]   mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (count == CNTW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNTW'(DEPTH)); // R1

    AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (count == $past(count))); // R1

    AST_POP_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush && !empty) |=> (count == $past(count) - CNTW'(1))); // R10

endmodule

// File: rtl/cmdseq_rd_packer.sv
module cmdseq_rd_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic        flush,
    input  logic        drop,
    output logic        word_vld,
    output logic [31:0] word
);
    logic [31:0] acc;
    logic [1:0]  pos;
    logic [31:0] merged;

    always_comb begin
        merged = acc;
        merged[{pos, 3'b000} +: 8] = byte_in;
    end

    assign word_vld = (byte_vld && pos == 2'd3) || (flush && pos != 2'd0);
    assign word     = byte_vld ? merged : acc;

    always_ff @(posedge clk) begin
        if (rst || drop) begin
            acc <= '0;
            pos <= '0;
        end else if (byte_vld) begin
            if (pos == 2'd3) begin
                acc <= '0;
                pos <= '0;
            end else begin
                acc <= merged;
                pos <= pos + 2'd1;
            end
        end else if (flush) begin
            acc <= '0;
            pos <= '0;
        end
    end

    AST_PACK_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        !(byte_vld && flush)); // R5

endmodule

// File: rtl/cmdseq_engine.sv
module cmdseq_engine
    import i2c_cmdseq_pkg::*;
#(
    parameter int CNTW        = 7,
    parameter int NUM_MASTERS = 2,
    parameter int MASTER_ID   = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NQ*NUM_MASTERS-1:0]  start_vec,
    input  logic [CNTW-1:0]            run_words,
    input  logic [NQ-1:0][31:0]        q_head,
    input  logic [NQ-1:0][CNTW-1:0]    q_cnt,
    output logic [NQ-1:0]              q_pop,
    output logic [NQ-1:0]              q_flush,
    output logic                       bus_req,
    output bus_kind_e                  bus_kind,
    output logic [7:0]                 bus_wdata,
    output logic                       bus_last,
    input  logic                       bus_ack,
    input  logic                       bus_nack,
    input  logic [7:0]                 bus_rdata,
    output logic                       rb_byte_vld,
    output logic [7:0]                 rb_byte,
    output logic                       rb_flush,
    output logic                       rb_drop,
    output logic [NQ-1:0]              ev_report,
    output logic                       ev_rd_done,
    output logic [NQ-1:0]              ev_nack,
    output logic [NQ-1:0]              ev_err,
    output logic                       busy
);
    seq_state_e               state;
    logic [NQ-1:0]            pend, pend_n, my_start;
    logic [NQ-1:0][CNTW-1:0]  lim_r;
    logic                     act_q, pick;
    logic [CNTW-1:0]          limit, exec_cnt;
    logic [31:0]              cur_word;
    logic [6:0]               addr7;
    logic [3:0]               len_left;
    logic [2:0]               byte_pos;
    logic                     is_read, nack_f, err_f;
    logic                     word_avail;

    always_comb begin
        my_start = '0;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            if (m == MASTER_ID) my_start = my_start | start_vec[m*NQ +: NQ];
        end
    end

    assign pick       = pend[0] ? 1'b0 : 1'b1;
    assign word_avail = (exec_cnt != limit) && (q_cnt[act_q] != '0);
    assign busy       = (state != S_IDLE) || (pend != '0);

    always_comb begin
        pend_n = pend;
        if (state == S_IDLE && pend != '0) pend_n[pick] = 1'b0;
        pend_n = pend_n | my_start;
    end

    always_comb begin
        q_pop       = '0;
        q_flush     = '0;
        bus_req     = 1'b0;
        bus_kind    = BK_STOP;
        bus_wdata   = '0;
        bus_last    = 1'b0;
        rb_byte_vld = 1'b0;
        rb_byte     = bus_rdata;
        rb_flush    = 1'b0;
        rb_drop     = 1'b0;
        case (state)
            S_FETCH: if (word_avail) q_pop[act_q] = 1'b1;
            S_EXEC: if (op_of(cur_word) == OP_READ) begin
                rb_byte_vld = 1'b1;
                rb_byte     = {addr7, 1'b1};
            end
            S_ADDR: begin
                bus_req   = 1'b1;
                bus_kind  = BK_ADDR;
                bus_wdata = {addr7, is_read};
            end
            S_WNEXT: if (byte_pos == 3'd4 && word_avail) q_pop[act_q] = 1'b1;
            S_WDATA: begin
                bus_req   = 1'b1;
                bus_kind  = BK_WRITE;
                bus_wdata = cur_word[{byte_pos[1:0], 3'b000} +: 8];
            end
            S_RDATA: begin
                bus_req     = 1'b1;
                bus_kind    = BK_READ;
                bus_last    = (len_left == 4'd1);
                rb_byte_vld = bus_ack;
            end
            S_STOP: begin
                bus_req  = 1'b1;
                bus_kind = BK_STOP;
                rb_flush = bus_ack && is_read && !nack_f && !err_f;
            end
            S_ABORT: begin
                q_flush[act_q] = 1'b1;
                rb_drop        = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            pend       <= '0;
            lim_r      <= '0;
            act_q      <= 1'b0;
            limit      <= '0;
            exec_cnt   <= '0;
            cur_word   <= '0;
            addr7      <= '0;
            len_left   <= '0;
            byte_pos   <= '0;
            is_read    <= 1'b0;
            nack_f     <= 1'b0;
            err_f      <= 1'b0;
            ev_report  <= '0;
            ev_rd_done <= 1'b0;
            ev_nack    <= '0;
            ev_err     <= '0;
        end else begin
            ev_report  <= '0;
            ev_rd_done <= 1'b0;
            ev_nack    <= '0;
            ev_err     <= '0;
            pend       <= pend_n;
            for (int q = 0; q < NQ; q++) begin
                if (my_start[q]) lim_r[q] <= run_words;
            end
            case (state)
                S_IDLE: if (pend != '0) begin
                    act_q    <= pick;
                    limit    <= lim_r[pick];
                    exec_cnt <= '0;
                    state    <= S_FETCH;
                end
                S_FETCH: if (word_avail) begin
                    cur_word <= q_head[act_q];
                    exec_cnt <= exec_cnt + CNTW'(1);
                    state    <= S_EXEC;
                end else begin
                    state <= S_IDLE;
                end
                S_EXEC: begin
                    case (op_of(cur_word))
                        OP_SETP: begin
                            addr7 <= addr_of(cur_word);
                            state <= S_FETCH;
                        end
                        OP_REPORT: begin
                            if (irq_of(cur_word)) ev_report[act_q] <= 1'b1;
                            state <= S_FETCH;
                        end
                        OP_WRITE: begin
                            len_left <= len_of(cur_word);
                            byte_pos <= 3'd1;
                            is_read  <= 1'b0;
                            state    <= S_ADDR;
                        end
                        OP_READ: begin
                            len_left <= len_of(cur_word);
                            is_read  <= 1'b1;
                            state    <= S_ADDR;
                        end
                        default: begin
                            err_f <= 1'b1;
                            state <= S_ABORT;
                        end
                    endcase
                end
                S_ADDR: if (bus_ack) begin
                    if (bus_nack) begin
                        nack_f <= 1'b1;
                        state  <= S_STOP;
                    end else if (len_left == '0) begin
                        state <= S_STOP;
                    end else begin
                        state <= is_read ? S_RDATA : S_WNEXT;
                    end
                end
                S_WNEXT: begin
                    if (byte_pos == 3'd4) begin
                        if (word_avail) begin
                            cur_word <= q_head[act_q];
                            exec_cnt <= exec_cnt + CNTW'(1);
                            byte_pos <= 3'd0;
                            state    <= S_WDATA;
                        end else begin
                            err_f <= 1'b1;
                            state <= S_STOP;
                        end
                    end else begin
                        state <= S_WDATA;
                    end
                end
                S_WDATA: if (bus_ack) begin
                    byte_pos <= byte_pos + 3'd1;
                    len_left <= len_left - 4'd1;
                    if (bus_nack) begin
                        nack_f <= 1'b1;
                        state  <= S_STOP;
                    end else if (len_left == 4'd1) begin
                        state <= S_STOP;
                    end else begin
                        state <= S_WNEXT;
                    end
                end
                S_RDATA: if (bus_ack) begin
                    len_left <= len_left - 4'd1;
                    if (len_left == 4'd1) state <= S_STOP;
                end
                S_STOP: if (bus_ack) begin
                    if (nack_f || err_f) begin
                        state <= S_ABORT;
                    end else begin
                        if (is_read) ev_rd_done <= 1'b1;
                        state <= S_FETCH;
                    end
                end
                S_ABORT: begin
                    if (nack_f) ev_nack[act_q] <= 1'b1;
                    else        ev_err[act_q]  <= 1'b1;
                    nack_f  <= 1'b0;
                    err_f   <= 1'b0;
                    is_read <= 1'b0;
                    state   <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_EXEC_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |-> (exec_cnt <= limit)); // R7

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_kind) && $stable(bus_wdata))); // R4

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_nack, ev_err, ev_rd_done})); // R8

endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
    import i2c_cmdseq_pkg::*;
#(
    parameter int Q0_DEPTH    = 64,
    parameter int Q1_DEPTH    = 16,
    parameter int RBUF_DEPTH  = 8,
    parameter int NUM_MASTERS = 2,
    parameter int MASTER_ID   = 0,
    localparam int QMAX       = (Q0_DEPTH > Q1_DEPTH) ? Q0_DEPTH : Q1_DEPTH,
    localparam int CNTW       = $clog2(QMAX + 1),
    localparam int RBW        = $clog2(RBUF_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ld_valid,
    input  logic                        ld_sel,
    input  logic [31:0]                 ld_word,
    input  logic [2*NUM_MASTERS-1:0]    start_vec,
    input  logic [CNTW-1:0]             run_words,
    output logic [CNTW-1:0]             q0_words,
    output logic [CNTW-1:0]             q1_words,
    output logic                        bus_req,
    output logic [1:0]                  bus_kind,
    output logic [7:0]                  bus_wdata,
    output logic                        bus_last,
    input  logic                        bus_ack,
    input  logic                        bus_nack,
    input  logic [7:0]                  bus_rdata,
    input  logic                        rd_pop,
    output logic [31:0]                 rd_word,
    output logic [RBW-1:0]              rd_level,
    output logic [1:0]                  ev_report,
    output logic                        ev_rd_done,
    output logic [1:0]                  ev_nack,
    output logic [1:0]                  ev_err,
    output logic                        busy
);
    logic [NQ-1:0][31:0]     q_head;
    logic [NQ-1:0][CNTW-1:0] q_cnt;
    logic [NQ-1:0]           q_pop, q_flush;
    bus_kind_e               kind_w;
    logic                    rb_byte_vld, rb_flush, rb_drop, rb_push;
    logic [7:0]              rb_byte;
    logic [31:0]             rb_word;

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        localparam int D = (g == 0) ? Q0_DEPTH : Q1_DEPTH;
        cmdseq_word_fifo #(.DEPTH(D), .CNTW(CNTW)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (ld_valid && (ld_sel == 1'(g))),
            .din   (ld_word),
            .pop   (q_pop[g]),
            .flush (q_flush[g]),
            .head  (q_head[g]),
            .count (q_cnt[g])
        );

        AST_NACK_FLUSHES: assert property (@(posedge clk) disable iff (rst)
            ev_nack[g] |-> (q_cnt[g] == '0)); // R8
    end

    assign q0_words = q_cnt[0];
    assign q1_words = q_cnt[1];

    cmdseq_engine #(
        .CNTW        (CNTW),
        .NUM_MASTERS (NUM_MASTERS),
        .MASTER_ID   (MASTER_ID)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start_vec   (start_vec),
        .run_words   (run_words),
        .q_head      (q_head),
        .q_cnt       (q_cnt),
        .q_pop       (q_pop),
        .q_flush     (q_flush),
        .bus_req     (bus_req),
        .bus_kind    (kind_w),
        .bus_wdata   (bus_wdata),
        .bus_last    (bus_last),
        .bus_ack     (bus_ack),
        .bus_nack    (bus_nack),
        .bus_rdata   (bus_rdata),
        .rb_byte_vld (rb_byte_vld),
        .rb_byte     (rb_byte),
        .rb_flush    (rb_flush),
        .rb_drop     (rb_drop),
        .ev_report   (ev_report),
        .ev_rd_done  (ev_rd_done),
        .ev_nack     (ev_nack),
        .ev_err      (ev_err),
        .busy        (busy)
    );

    assign bus_kind = kind_w;

    cmdseq_rd_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (rb_byte_vld),
        .byte_in  (rb_byte),
        .flush    (rb_flush),
        .drop     (rb_drop),
        .word_vld (rb_push),
        .word     (rb_word)
    );

    cmdseq_word_fifo #(.DEPTH(RBUF_DEPTH), .CNTW(RBW)) u_rbuf (
        .clk   (clk),
        .rst   (rst),
        .push  (rb_push),
        .din   (rb_word),
        .pop   (rd_pop),
        .flush (1'b0),
        .head  (rd_word),
        .count (rd_level)
    );

endmodule

// File: tb/i2c_cmd_sequencer_test.sv
module i2c_cmd_sequencer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0, ld_sel = 1'b0;
    logic [31:0] ld_word = '0;
    logic [3:0]  start_vec = '0;
    logic [6:0]  run_words = '0;
    logic [6:0]  q0_words, q1_words;
    logic        bus_req, bus_last, bus_ack, bus_nack;
    logic [1:0]  bus_kind;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_word;
    logic [3:0]  rd_level;
    logic [1:0]  ev_report, ev_nack, ev_err;
    logic        ev_rd_done, busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cmd_sequencer uut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_word(ld_word),
        .start_vec(start_vec), .run_words(run_words), .q0_words(q0_words), .q1_words(q1_words),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_wdata(bus_wdata), .bus_last(bus_last),
        .bus_ack(bus_ack), .bus_nack(bus_nack), .bus_rdata(bus_rdata), .rd_pop(rd_pop),
        .rd_word(rd_word), .rd_level(rd_level), .ev_report(ev_report), .ev_rd_done(ev_rd_done),
        .ev_nack(ev_nack), .ev_err(ev_err), .busy(busy)
    );

    int tests = 0, fails = 0;
    int n_log = 0, nack_at = -1;
    logic [1:0] lk [64];
    logic [7:0] lb [64];
    logic       ll [64];
    int rep_cnt [2], nack_cnt [2], err_cnt [2], done_cnt = 0;
    int ord [8];
    int ord_n = 0;

    // bus engine model: acknowledges every request on the next falling edge
    initial begin
        bus_ack = 1'b0; bus_nack = 1'b0; bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0; bus_nack = 1'b0;
            end else if (bus_req && !rst) begin
                if (n_log < 64) begin
                    lk[n_log] = bus_kind; lb[n_log] = bus_wdata; ll[n_log] = bus_last;
                end
                bus_rdata = 8'h5A ^ 8'(n_log * 13);
                bus_nack  = (n_log == nack_at);
                n_log++;
                bus_ack = 1'b1;
            end
        end
    end

    initial begin
        for (int q = 0; q < 2; q++) begin rep_cnt[q] = 0; nack_cnt[q] = 0; err_cnt[q] = 0; end
        forever begin
            @(negedge clk);
            for (int q = 0; q < 2; q++) begin
                if (ev_report[q]) begin
                    rep_cnt[q]++;
                    if (ord_n < 8) begin ord[ord_n] = q; ord_n++; end
                end
                if (ev_nack[q]) nack_cnt[q]++;
                if (ev_err[q])  err_cnt[q]++;
            end
            if (ev_rd_done) done_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int q, input logic [31:0] w);
        @(negedge clk);
        ld_valid = 1'b1; ld_sel = q[0]; ld_word = w;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 3000) begin @(negedge clk); k++; end
        chk(k < 3000, "R7 run finishes", k, 0);
        @(negedge clk);
    endtask

    task automatic run(input int bitpos, input int lim);
        @(negedge clk);
        start_vec = 4'(1 << bitpos); run_words = 7'(lim);
        @(negedge clk);
        start_vec = '0;
        wait_idle();
    endtask

    task automatic pop_word();
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    function automatic logic [31:0] cmd_setp(input logic [6:0] a);
        return 32'(4'd1) | (32'(a) << 4);
    endfunction

    localparam logic [31:0] REP_IRQ = 32'h108;
    localparam logic [31:0] REP_QUIET = 32'h008;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] bytes [20];
        int r0, mism, nw, lvl;
        logic [31:0] w, exp_w;
        logic [6:0] a;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 R10 reset state
        chk(q0_words == 0 && q1_words == 0, "R1 reset counts", q0_words + q1_words, 0);
        chk(rd_level == 0 && !busy && !bus_req, "R10 reset level/busy", rd_level, 0);

        // R1 queue 1 fill beyond depth; R6 quiet reports raise nothing
        for (int i = 0; i < 17; i++) load(1, REP_QUIET);
        chk(q1_words == 16, "R1 full queue drops", q1_words, 16);
        r0 = rep_cnt[1];
        run(1, 16);
        chk(rep_cnt[1] == r0, "R6 report without irq bit", rep_cnt[1] - r0, 0);
        chk(q1_words == 0, "R7 all words consumed", q1_words, 0);

        // R4 R3 write sweep on queue 0
        for (int len = 0; len < 16; len++) begin
            a = 7'h20 + 7'(len);
            bytes[0] = 8'h09 | 8'(len << 4);
            for (int i = 1; i < 20; i++) bytes[i] = (i <= len) ? 8'(i * 37 + len) : 8'h00;
            nw = len / 4 + 1;
            load(0, cmd_setp(a));
            for (int k = 0; k < nw; k++)
                load(0, {bytes[4*k+3], bytes[4*k+2], bytes[4*k+1], bytes[4*k]});
            load(0, REP_IRQ);
            n_log = 0; r0 = rep_cnt[0];
            run(0, nw + 2);
            chk(n_log == len + 2, "R4 write op count", n_log, len + 2);
            chk(lk[0] == 2'd0 && lb[0] == {a, 1'b0}, "R3 write address byte", lb[0], {a, 1'b0});
            mism = 0;
            for (int i = 1; i <= len; i++) if (lk[i] != 2'd1 || lb[i] != bytes[i]) mism++;
            chk(mism == 0, "R4 write data bytes in order", mism, 0);
            chk(lk[len + 1] == 2'd3, "R4 write closes with stop", lk[len + 1], 3);
            chk(rep_cnt[0] == r0 + 1, "R6 report with irq bit", rep_cnt[0] - r0, 1);
            chk(q0_words == 0, "R7 write run drained", q0_words, 0);
        end

        // R5 read sweep on queue 1, R10 buffer drain
        for (int len = 0; len < 16; len++) begin
            a = 7'h41 + 7'(len);
            load(1, cmd_setp(a));
            load(1, 32'(4'd10) | 32'(len << 4));
            n_log = 0; r0 = done_cnt;
            run(1, 2);
            chk(n_log == len + 2, "R5 read op count", n_log, len + 2);
            chk(lk[0] == 2'd0 && lb[0] == {a, 1'b1}, "R3 read address byte", lb[0], {a, 1'b1});
            mism = 0;
            for (int i = 1; i <= len; i++) if (lk[i] != 2'd2 || ll[i] != (i == len)) mism++;
            chk(mism == 0, "R5 read ops and last flag", mism, 0);
            chk(done_cnt == r0 + 1, "R5 read done pulse", done_cnt - r0, 1);
            chk(rd_level == 4'(len / 4 + 1), "R5 read word count", rd_level, len / 4 + 1);
            bytes[0] = {a, 1'b1};
            for (int i = 1; i < 20; i++) bytes[i] = (i <= len) ? (8'h5A ^ 8'(i * 13)) : 8'h00;
            mism = 0;
            for (int k = 0; k <= len / 4; k++) begin
                exp_w = {bytes[4*k+3], bytes[4*k+2], bytes[4*k+1], bytes[4*k]};
                if (rd_word != exp_w) mism++;
                lvl = int'(rd_level);
                pop_word();
                if (int'(rd_level) != lvl - 1) mism++;
            end
            chk(mism == 0, "R10 read words and level steps", mism, 0);
            chk(rd_level == 0, "R10 buffer emptied", rd_level, 0);
        end

        // R7 limit leaves words behind
        for (int i = 0; i < 3; i++) load(0, REP_IRQ);
        r0 = rep_cnt[0];
        run(0, 2);
        chk(rep_cnt[0] == r0 + 2, "R7 limit of two", rep_cnt[0] - r0, 2);
        chk(q0_words == 1, "R7 word kept past limit", q0_words, 1);
        run(0, 5);
        chk(rep_cnt[0] == r0 + 3 && q0_words == 0, "R7 queue empties first", rep_cnt[0] - r0, 3);

        // R2 start bit of another master is ignored
        load(0, REP_IRQ);
        r0 = rep_cnt[0];
        @(negedge clk); start_vec = 4'b0100; run_words = 7'd1;
        @(negedge clk); start_vec = '0;
        repeat (5) @(negedge clk);
        chk(!busy && q0_words == 1 && rep_cnt[0] == r0, "R2 foreign start bit", q0_words, 1);
        run(0, 1);
        chk(q0_words == 0 && rep_cnt[0] == r0 + 1, "R2 own start bit", rep_cnt[0] - r0, 1);

        // R11 priority with simultaneous starts
        load(0, REP_IRQ); load(1, REP_IRQ);
        ord_n = 0;
        @(negedge clk); start_vec = 4'b0011; run_words = 7'd1;
        @(negedge clk); start_vec = '0;
        wait_idle();
        chk(ord_n == 2 && ord[0] == 0 && ord[1] == 1, "R11 queue 0 first", ord[0], 0);

        // R11 start held while busy
        for (int i = 0; i < 4; i++) load(0, REP_IRQ);
        load(1, REP_IRQ);
        r0 = rep_cnt[1];
        @(negedge clk); start_vec = 4'b0001; run_words = 7'd4;
        @(negedge clk); start_vec = 4'b0010; run_words = 7'd1;
        @(negedge clk); start_vec = '0;
        wait_idle();
        chk(rep_cnt[1] == r0 + 1 && q0_words == 0, "R11 pending start kept", rep_cnt[1] - r0, 1);

        // R8 NACK on address, then on a data byte
        for (int s = 0; s < 2; s++) begin
            load(0, cmd_setp(7'h33));
            load(0, 32'hCCBBAA39);
            load(0, REP_IRQ);
            load(0, REP_IRQ);
            nack_at = (s == 0) ? 0 : 2;
            n_log = 0; r0 = rep_cnt[0];
            run(0, 4);
            nack_at = -1;
            chk(nack_cnt[0] == s + 1, "R8 nack event", nack_cnt[0], s + 1);
            chk(q0_words == 0 && rep_cnt[0] == r0, "R8 queue discarded", q0_words, 0);
            chk(n_log == nack_at + 4 + s * 2 - s * 2 + (s == 0 ? -2 : -2) + 0 || lk[n_log - 1] == 2'd3,
                "R8 stop after nack", lk[n_log - 1], 3);
        end

        // R9 bad opcode and truncated write
        load(0, 32'h0000_0005);
        load(0, REP_IRQ);
        r0 = rep_cnt[0];
        run(0, 2);
        chk(err_cnt[0] == 1 && q0_words == 0 && rep_cnt[0] == r0, "R9 unknown opcode", err_cnt[0], 1);
        load(0, cmd_setp(7'h12));
        load(0, 32'h33221159);
        load(0, 32'h00005544);
        n_log = 0;
        run(0, 2);
        chk(err_cnt[0] == 2 && q0_words == 0, "R9 truncated write", err_cnt[0], 2);
        chk(n_log == 5 && lk[4] == 2'd3, "R9 stop closes cut write", n_log, 5);
        chk(nack_cnt[0] == 2 && nack_cnt[1] == 0 && err_cnt[1] == 0, "R8 R9 no stray events",
            nack_cnt[1] + err_cnt[1], 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule